// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready Handshake

This block receives asynchronous serial characters on a single input line and generates its own bit timing. The timing base is either the system clock or the system clock divided by eight. A reloadable down-counter divides it by (setting + 1), and a sixteen-step oversampling counter then divides it again. A falling edge on the line starts a character. The start bit is confirmed at its middle, and each following bit is sampled once at its own middle. Data arrives least significant bit first. Parity is optional and can be even or odd, and the character ends with one or two stop bits.

When a character is complete it moves from the shift register into a holding register. A full flag and an interrupt request are raised at the same time. Framing and parity errors are captured alongside the data. If a character completes while the previous one has not been read, an overrun is flagged and the held data is kept. An active-low ready-to-send output tells the far end when the receiver can accept data. It goes not-ready as soon as a start bit is accepted and stays not-ready until the character has been read.

Top module: `uart_rx_rts`

## Requirements
- R1: One bit time lasts 16 × (div_set + 1) count-source cycles. The count source is the clock when src_div8 = 0 and the clock divided by 8 when src_div8 = 1.
- R2: While rx_en = 1, a character starts on a high-to-low transition of rxd. The start bit is checked again at its middle (the 8th of 16 oversampling ticks). If the line is high there, the receiver returns to idle and no output changes. While rx_en = 0, line activity has no effect.
- R3: Data is 8 bits. The first bit after the start bit lands in rx_data[0] and the last in rx_data[7].
- R4: With parity_en = 1, one parity bit follows the data. With parity_odd = 0 the data plus parity bit must hold an even number of ones; with parity_odd = 1, an odd number. A mismatch sets err_parity together with the loaded character.
- R5: stop2 = 0 expects one stop bit and stop2 = 1 expects two. If any stop bit is sampled low, err_framing is set together with the loaded character.
- R6: When a character completes and rx_full = 0, it is loaded into rx_data and rx_full becomes 1. A one-cycle rd_strobe clears rx_full, err_framing, err_parity and err_overrun.
- R7: irq becomes 1 when any character completes. It is cleared by a one-cycle irq_ack or by a one-cycle irq_clr.
- R8: If a character completes while rx_full = 1, err_overrun becomes 1, and rx_data, err_framing and err_parity are not changed.
- R9: With rts_en = 1, rts_n = 1 while rx_en = 0. With rx_en = 1, rts_n = 0 until a start bit is accepted, then 1 until the next rd_strobe. With rts_en = 0, rts_n = 0 at all times.
- R10: After reset, rx_data = 0 and rx_full, irq, err_framing, err_parity and err_overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| src_div8 | input | 1 | Count source select: 0 = clock, 1 = clock/8 |
| div_set | input | 8 | Divider reload value n (divide by n+1) |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| rts_en | input | 1 | Ready-to-send output function enable |
| rxd | input | 1 | Serial receive line (idle high) |
| rd_strobe | input | 1 | One-cycle pulse: character has been read |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr | input | 1 | Software clear of the interrupt request |
| rx_data | output | 8 | Received character holding register |
| rx_full | output | 1 | Receive-complete flag |
| irq | output | 1 | Receive interrupt request |
| err_framing | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Character completed while rx_full was set |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
The hardest case to reach is a start edge that fails the mid-bit check. Only a low pulse on rxd that is shorter than half a bit time takes the receiver back to idle. Otherwise the receiver would either load a character or raise the ready-to-send line. The bench drives a quarter-bit low pulse and keeps comparing every output against its model on every clock during the pulse and for two bit times after it. Overrun is reached by sending two characters back to back with no read between them.

// File: rtl/urx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: nothing beyond standard SystemVerilog.
package urx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } urx_state_e;
endpackage

// File: rtl/urx_tick_gen.sv
// Oversampling tick generator. A prescaler (1 or PRE) feeds a reloading
// down-counter, and one tick is produced every (div_set+1) prescaled cycles.
// Assumes: PRE is a power of two; counters restart while en is low.
module urx_tick_gen #(
    parameter int DIV_W = 8,
    parameter int PRE   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             src_slow,
    input  logic [DIV_W-1:0] div_set,
    output logic             tick
);
    localparam int PRE_W = (PRE > 1) ? $clog2(PRE) : 1;

    logic [PRE_W-1:0] pcnt;
    logic [DIV_W-1:0] bcnt;
    logic             pre_tick;

    assign pre_tick = src_slow ? (pcnt == PRE_W'(PRE - 1)) : 1'b1;
    assign tick     = en && pre_tick && (bcnt == '0);

    // Prescaler: free-running modulo-PRE count while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pcnt <= '0;
        else               pcnt <= (pcnt == PRE_W'(PRE - 1)) ? '0 : pcnt + 1'b1;
    end

    // Reload divider: counts down on each prescaled cycle, reloads at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  bcnt <= '0;
        else if (pre_tick)  bcnt <= (bcnt == '0) ? div_set : bcnt - 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_set != '0)) |=> !tick); // R1
endmodule

// File: rtl/urx_frame_fsm.sv
// Character framer: synchronises the line, detects a start edge, confirms
// the start bit at mid-bit, shifts data LSB first, then takes the optional
// parity bit and one or two stop bits. A one-cycle done pulse carries the
// character and its error bits.
// Assumes: tick is the 16x oversampling strobe; rxd is asynchronous.
module urx_frame_fsm
    import urx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              stop2,
    output logic              accept,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              fe,
    output logic              pe
);
    localparam int OS_W = $clog2(OVS);
    localparam int MID  = OVS / 2 - 1;
    localparam int BI_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    urx_state_e        state;
    logic [OS_W-1:0]   os;
    logic [BI_W-1:0]   bit_idx;
    logic              stop_idx;
    logic [DATA_W-1:0] sh;
    logic              par_bit;
    logic              fe_acc;
    logic              s1, s2, s3;
    logic              line, fall, sample;

    assign line   = s2;
    assign fall   = s3 && !s2;
    assign sample = tick && (os == OS_W'(MID));

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Frame sequencing: oversampling count and mid-bit sampling per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            os       <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            sh       <= '0;
            par_bit  <= 1'b0;
            fe_acc   <= 1'b0;
            accept   <= 1'b0;
            done     <= 1'b0;
            data     <= '0;
            fe       <= 1'b0;
            pe       <= 1'b0;
        end else begin
            accept <= 1'b0;
            done   <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
            end else if (state == ST_IDLE) begin
                if (fall) begin
                    state <= ST_START;
                    os    <= '0;
                end
            end else if (tick) begin
                os <= os + 1'b1;
                if (sample) begin
                    case (state)
                        ST_START: begin
                            if (!line) begin
                                state    <= ST_DATA;
                                bit_idx  <= '0;
                                fe_acc   <= 1'b0;
                                stop_idx <= 1'b0;
                                accept   <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_DATA: begin
                            sh <= {line, sh[DATA_W-1:1]};
                            if (bit_idx == BI_W'(DATA_W - 1))
                                state <= parity_en ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                        ST_PAR: begin
                            par_bit <= line;
                            state   <= ST_STOP;
                        end
                        ST_STOP: begin
                            if (stop2 && !stop_idx) begin
                                stop_idx <= 1'b1;
                                fe_acc   <= fe_acc | !line;
                            end else begin
                                done  <= 1'b1;
                                data  <= sh;
                                fe    <= fe_acc | !line;
                                pe    <= parity_en & ((^sh) ^ par_bit ^ parity_odd);
                                state <= ST_IDLE;
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    AST_START_CONFIRMED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !$past(line)); // R2
    AST_OFF_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
endmodule

// File: rtl/urx_rx_buffer.sv
// Holding register and status: loads completed characters, keeps errors,
// flags overrun, raises the interrupt request and holds the not-ready state
// for the handshake output.
// Assumes: done and accept are one-cycle pulses from the framer.
module urx_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              accept,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              fe,
    input  logic              pe,
    input  logic              rd,
    input  logic              ack,
    input  logic              clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              err_fe,
    output logic              err_pe,
    output logic              err_ovr,
    output logic              irq,
    output logic              hold
);
    // Buffer and error flags: a read clears, a completion loads or overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            full    <= 1'b0;
            err_fe  <= 1'b0;
            err_pe  <= 1'b0;
            err_ovr <= 1'b0;
        end else begin
            if (rd) begin
                full    <= 1'b0;
                err_fe  <= 1'b0;
                err_pe  <= 1'b0;
                err_ovr <= 1'b0;
            end
            if (done) begin
                if (full && !rd) begin
                    err_ovr <= 1'b1;
                end else begin
                    rx_data <= data;
                    full    <= 1'b1;
                    err_fe  <= fe;
                    err_pe  <= pe;
                end
            end
        end
    end

    // Interrupt request: set on completion, cleared by acknowledge or software.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (done)      irq <= 1'b1;
        else if (ack | clr) irq <= 1'b0;
    end

    // Not-ready hold: set when a start bit is accepted, released by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)             hold <= 1'b0;
        else if (accept)        hold <= 1'b1;
        else if (rd || !rx_en)  hold <= 1'b0;
    end

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd) |=> (err_ovr && $stable(rx_data))); // R8
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq); // R7
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !full); // R6
endmodule

// File: rtl/uart_rx_rts.sv
// Top level of the serial receiver: tick generator, framer and holding
// buffer, plus the active-low ready-to-send output.
// Assumes: control inputs change only while no character is in flight.
module uart_rx_rts #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int OVS    = 16,
    parameter int PRE    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              src_div8,
    input  logic [DIV_W-1:0]  div_set,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              stop2,
    input  logic              rts_en,
    input  logic              rxd,
    input  logic              rd_strobe,
    input  logic              irq_ack,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              irq,
    output logic              err_framing,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              rts_n
);
    logic              tick;
    logic              accept, done, f_fe, f_pe, hold;
    logic [DATA_W-1:0] f_data;

    urx_tick_gen #(.DIV_W(DIV_W), .PRE(PRE)) i_tick (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .src_slow(src_div8),
        .div_set(div_set), .tick(tick)
    );

    urx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) i_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .rxd(rxd),
        .parity_en(parity_en), .parity_odd(parity_odd), .stop2(stop2),
        .accept(accept), .done(done), .data(f_data), .fe(f_fe), .pe(f_pe)
    );

    urx_rx_buffer #(.DATA_W(DATA_W)) i_buf (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .accept(accept), .done(done),
        .data(f_data), .fe(f_fe), .pe(f_pe), .rd(rd_strobe), .ack(irq_ack),
        .clr(irq_clr), .rx_data(rx_data), .full(rx_full), .err_fe(err_framing),
        .err_pe(err_parity), .err_ovr(err_overrun), .irq(irq), .hold(hold)
    );

    // Handshake output: not-ready when disabled or while a character is held.
    assign rts_n = rts_en && (!rx_en || hold);

    AST_RTS_WHEN_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && rx_en && rts_en) |-> rts_n); // R9
endmodule

// File: tb/test_uart_rx_rts.sv
module test_uart_rx_rts;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, src_div8 = 1'b0;
    logic [7:0] div_set = 8'd3;
    logic       parity_en = 1'b0, parity_odd = 1'b0, stop2 = 1'b0;
    logic       rts_en = 1'b1, rxd = 1'b1;
    logic       rd_strobe = 1'b0, irq_ack = 1'b0, irq_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, irq, err_framing, err_parity, err_overrun, rts_n;

    int total = 0;
    int bad   = 0;
    bit settled = 1'b0;

    // behavioural model state
    logic [7:0] m_data = 8'h00;
    bit m_full = 0, m_irq = 0, m_fe = 0, m_pe = 0, m_ovr = 0, m_hold = 0;

    always #4 clk = ~clk;

    uart_rx_rts i_uart_rx_rts (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .src_div8(src_div8),
        .div_set(div_set), .parity_en(parity_en), .parity_odd(parity_odd),
        .stop2(stop2), .rts_en(rts_en), .rxd(rxd), .rd_strobe(rd_strobe),
        .irq_ack(irq_ack), .irq_clr(irq_clr), .rx_data(rx_data),
        .rx_full(rx_full), .irq(irq), .err_framing(err_framing),
        .err_parity(err_parity), .err_overrun(err_overrun), .rts_n(rts_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model while no character is in flight
    always @(negedge clk) begin
        if (settled && rst_n) begin
            chk("R6 rx_data", rx_data, m_data);
            chk("R6 rx_full", rx_full, m_full);
            chk("R7 irq", irq, m_irq);
            chk("R5 err_framing", err_framing, m_fe);
            chk("R4 err_parity", err_parity, m_pe);
            chk("R8 err_overrun", err_overrun, m_ovr);
            chk("R9 rts_n", rts_n, int'(rts_en && (!rx_en || m_hold)));
        end
    end

    function automatic int bit_clks();
        return 16 * (int'(div_set) + 1) * (src_div8 ? 8 : 1);
    endfunction

    task automatic bit_out(input logic v);
        @(posedge clk); #1 rxd = v;
        repeat (bit_clks() - 1) @(posedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                         input bit live, input bit rts_probe);
        if (live) settled = 1'b0;
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) begin
            bit_out(d[i]);
            if (i == 0 && rts_probe) begin
                #2 chk("R9 rts_n in frame", rts_n, int'(rts_en));
            end
        end
        if (parity_en) bit_out((^d) ^ parity_odd ^ bad_par);
        bit_out(!bad_stop);
        if (stop2) bit_out(1'b1);
        @(posedge clk); #1 rxd = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        if (live) begin
            m_irq  = 1;
            m_hold = 1;
            if (m_full) m_ovr = 1;
            else begin
                m_data = d; m_full = 1;
                m_fe = bad_stop; m_pe = parity_en && bad_par;
            end
            settled = 1'b1;
        end
    endtask

    task automatic do_read();
        @(posedge clk); #1 rd_strobe = 1'b1;
        @(posedge clk); #1 rd_strobe = 1'b0;
        m_full = 0; m_fe = 0; m_pe = 0; m_ovr = 0; m_hold = 0;
    endtask

    task automatic pulse_ack(input bit sw);
        @(posedge clk); #1 if (sw) irq_clr = 1'b1; else irq_ack = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0; irq_ack = 1'b0;
        m_irq = 0;
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1 rx_en = v;
        if (!v) m_hold = 0;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 rx_data", rx_data, 0);
        chk("R10 rx_full", rx_full, 0);
        chk("R10 irq", irq, 0);
        chk("R10 errors", {err_framing, err_parity, err_overrun}, 0);
        settled = 1'b1;
        set_en(1'b1);

        // R3, R9: plain character, LSB first, handshake during frame
        frame(8'hA5, 0, 0, 1, 1);
        chk("R3 data order", rx_data, 8'hA5);
        do_read();
        @(negedge clk); chk("R9 ready after read", rts_n, 0);

        // R4: even ok, odd ok, odd mismatch
        @(posedge clk); #1 parity_en = 1'b1; parity_odd = 1'b0;
        frame(8'h3C, 0, 0, 1, 0);
        chk("R4 even ok", err_parity, 0);
        do_read();
        @(posedge clk); #1 parity_odd = 1'b1;
        frame(8'h3D, 0, 0, 1, 0);
        chk("R4 odd ok", err_parity, 0);
        do_read();
        frame(8'h5A, 1, 0, 1, 0);
        chk("R4 odd mismatch", err_parity, 1);
        chk("R4 data", rx_data, 8'h5A);
        do_read();

        // R5: two stop bits ok and bad, one bad stop
        @(posedge clk); #1 parity_en = 1'b0; stop2 = 1'b1;
        frame(8'hC3, 0, 0, 1, 0);
        chk("R5 two stop ok", err_framing, 0);
        do_read();
        frame(8'hC4, 0, 1, 1, 0);
        chk("R5 two stop bad", err_framing, 1);
        do_read();
        @(posedge clk); #1 stop2 = 1'b0;
        frame(8'h7E, 0, 1, 1, 0);
        chk("R5 one stop bad", err_framing, 1);
        do_read();

        // R8: overrun keeps first character
        frame(8'h11, 0, 0, 1, 0);
        frame(8'h22, 0, 0, 1, 0);
        chk("R8 overrun flag", err_overrun, 1);
        chk("R8 buffer kept", rx_data, 8'h11);
        do_read();

        // R7: acknowledge and software clear
        pulse_ack(1'b0);
        @(negedge clk); chk("R7 ack clears", irq, 0);
        frame(8'h33, 0, 0, 1, 0);
        chk("R7 set on done", irq, 1);
        pulse_ack(1'b1);
        @(negedge clk); chk("R7 clr clears", irq, 0);
        do_read();

        // R2: short low pulse is rejected
        @(posedge clk); #1 rxd = 1'b0;
        repeat (bit_clks() / 4) @(posedge clk);
        #1 rxd = 1'b1;
        repeat (bit_clks() * 2) @(posedge clk);
        @(negedge clk);
        chk("R2 glitch rts", rts_n, 0);
        chk("R2 glitch full", rx_full, 0);

        // R2, R9: disabled receiver ignores the line, signals not-ready
        set_en(1'b0);
        frame(8'h44, 0, 0, 0, 0);
        @(negedge clk);
        chk("R2 disabled full", rx_full, 0);
        chk("R9 disabled rts", rts_n, 1);
        set_en(1'b1);

        // R9: handshake function off keeps output low
        @(posedge clk); #1 rts_en = 1'b0;
        frame(8'h55, 0, 0, 1, 1);
        chk("R9 rts off", rts_n, 0);
        do_read();
        @(posedge clk); #1 rts_en = 1'b1;

        // R1: divided count source and the minimum divider
        @(posedge clk); #1 src_div8 = 1'b1; div_set = 8'd1;
        frame(8'h81, 0, 0, 1, 0);
        chk("R1 clk/8 source", rx_data, 8'h81);
        do_read();
        @(posedge clk); #1 src_div8 = 1'b0; div_set = 8'd0;
        frame(8'hF0, 0, 0, 1, 0);
        chk("R1 divider zero", rx_data, 8'hF0);
        do_read();

        repeat (10) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule